// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block turns a decoded single-item memory transfer into a memory request. From a base register value, an offset and a few control bits it computes the address to access, the transfer size and direction, and, for the indexing modes that update the base, the new base value together with a one-cycle enable for the register file write port.

The offset is either a zero-extended immediate or a full register value, and it is added to or subtracted from the base. Three indexing modes are supported. Plain offset accesses base±offset and leaves the base alone. Pre-indexed accesses base±offset and writes that same address back to the base. Post-indexed accesses the unmodified base and then writes base±offset back. All results are registered, so a request presented with `valid_i` high appears on the outputs after the next rising clock edge and lasts one cycle.

Top module: `lsu_agen`

## Requirements
- R1: While `rst_ni` is low and after its release until the first request, `rd_o`, `wr_o`, `wb_en_o`, `byte_o` and `word_o` are 0.
- R2: A request sampled with `valid_i`=1 at a rising edge drives the outputs from that edge until the next one; a cycle with `valid_i`=0 leaves `rd_o`, `wr_o` and `wb_en_o` low in the following cycle, and `wb_en_o` is never high without `rd_o` or `wr_o`.
- R3: `store_i`=1 raises `wr_o`, `store_i`=0 raises `rd_o`; the two are never high together.
- R4: Mode 0 (offset) gives `addr_o` = base±offset with `wb_en_o` low.
- R5: Mode 1 (pre-indexed) gives `addr_o` = base±offset, `wb_en_o` high and `wb_val_o` equal to `addr_o`.
- R6: Mode 2 (post-indexed) gives `addr_o` = base unchanged, `wb_en_o` high and `wb_val_o` = base±offset.
- R7: `off_reg_i`=0 selects `imm_i` zero-extended to 32 bits; `off_reg_i`=1 selects `roff_i` and ignores `imm_i`.
- R8: `sub_i`=1 subtracts the offset from the base; `sub_i`=0 adds it.
- R9: Address and writeback arithmetic wrap modulo 2^32 with no other effect.
- R10: `byte_i`=1 raises `byte_o`, `byte_i`=0 raises `word_o`; exactly one is high during a request, and `addr_o` carries all 32 bits unaltered, low bits included.
- R11: Mode 3 behaves as mode 0: address base±offset, no writeback.
- R12: An immediate offset of zero in mode 0 accesses the base address itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset, zero-extended |
| roff_i | input | 32 | Register offset value |
| off_reg_i | input | 1 | 1 selects register offset, 0 immediate |
| sub_i | input | 1 | 1 subtracts the offset |
| mode_i | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as 0 |
| store_i | input | 1 | 1 store, 0 load |
| byte_i | input | 1 | 1 byte transfer, 0 word |
| addr_o | output | 32 | Memory address |
| rd_o | output | 1 | Read request |
| wr_o | output | 1 | Write request |
| byte_o | output | 1 | Byte size strobe |
| word_o | output | 1 | Word size strobe |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | 32 | Base writeback value |

## Verification
Each indexing mode is driven with both offset sources and both signs, so a swapped pre/post route shows as the base appearing on the wrong output and a lost sign or source shows as a wrong address. A base near the top of the address space with a positive offset, and a small base with a larger subtracted offset, separate wrapping arithmetic from any saturation. An immediate of all ones tells zero extension from sign extension, and a register-offset case with a nonzero immediate shows the unused source has no effect. Idle cycles after each request confirm that the strobes and writeback enable are single pulses.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IMM_W  = 12;

  typedef enum logic [1:0] {
    IDX_OFF  = 2'd0,
    IDX_PRE  = 2'd1,
    IDX_POST = 2'd2,
    IDX_ALT  = 2'd3
  } idx_mode_e;
endpackage

// File: rtl/agen_offset_sel.sv
module agen_offset_sel #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 12
) (
  input  logic [IW-1:0] imm_i,
  input  logic [DW-1:0] roff_i,
  input  logic          off_reg_i,
  output logic [DW-1:0] off_o
);
  localparam int unsigned PAD_W = DW - IW;

  always_comb begin
    if (off_reg_i) off_o = roff_i;
    else           off_o = {{PAD_W{1'b0}}, imm_i};
  end
endmodule

// File: rtl/agen_addsub.sv
module agen_addsub #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o
);
  logic [DW-1:0] b_x;

  // two's complement subtract on one carry chain, wraps mod 2^DW
  assign b_x   = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_x + {{(DW-1){1'b0}}, sub_i};
endmodule

// File: rtl/agen_route.sv
module agen_route
  import agen_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] calc_i,
  output logic [DW-1:0] addr_o,
  output logic          wb_en_o
);
  idx_mode_e mode;

  assign mode = idx_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      IDX_PRE: begin
        addr_o  = calc_i;
        wb_en_o = 1'b1;
      end
      IDX_POST: begin
        addr_o  = base_i;
        wb_en_o = 1'b1;
      end
      default: begin
        addr_o  = calc_i;
        wb_en_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import agen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] roff_i,
  input  logic              off_reg_i,
  input  logic              sub_i,
  input  logic [1:0]        mode_i,
  input  logic              store_i,
  input  logic              byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              byte_o,
  output logic              word_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_val_o
);
  logic [ADDR_W-1:0] off, calc, addr_d;
  logic              wb_en_d;

  agen_offset_sel #(.DW(ADDR_W), .IW(IMM_W)) u_osel (
    .imm_i     (imm_i),
    .roff_i    (roff_i),
    .off_reg_i (off_reg_i),
    .off_o     (off)
  );

  agen_addsub #(.DW(ADDR_W)) u_add (
    .a_i   (base_i),
    .b_i   (off),
    .sub_i (sub_i),
    .sum_o (calc)
  );

  agen_route #(.DW(ADDR_W)) u_route (
    .mode_i  (mode_i),
    .base_i  (base_i),
    .calc_i  (calc),
    .addr_o  (addr_d),
    .wb_en_o (wb_en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      wb_val_o <= '0;
      rd_o     <= 1'b0;
      wr_o     <= 1'b0;
      byte_o   <= 1'b0;
      word_o   <= 1'b0;
      wb_en_o  <= 1'b0;
    end else begin
      rd_o    <= valid_i & ~store_i;
      wr_o    <= valid_i &  store_i;
      byte_o  <= valid_i &  byte_i;
      word_o  <= valid_i & ~byte_i;
      wb_en_o <= valid_i &  wb_en_d;
      if (valid_i) begin
        addr_o   <= addr_d;
        wb_val_o <= calc;
      end
    end
  end
endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] base_i,
  input logic [1:0]  mode_i,
  input logic        store_i,
  input logic        byte_i,
  input logic [31:0] addr_o,
  input logic        rd_o,
  input logic        wr_o,
  input logic        byte_o,
  input logic        word_o,
  input logic        wb_en_o,
  input logic [31:0] wb_val_o
);
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(rd_o && wr_o)); // R3
  AST_STORE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && store_i |=> wr_o); // R3
  AST_WB_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni) wb_en_o |-> (rd_o || wr_o)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !rd_o && !wr_o && !wb_en_o); // R2
  AST_NO_WB_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && (mode_i == 2'd0 || mode_i == 2'd3) |=> !wb_en_o); // R4
  AST_PRE_WB_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && mode_i == 2'd1 |=> wb_en_o && wb_val_o == addr_o); // R5
  AST_POST_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && mode_i == 2'd2 |=> wb_en_o && addr_o == $past(base_i)); // R6
  AST_SIZE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_o || wr_o) |-> (byte_o != word_o)); // R10
  AST_BYTE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && byte_i |=> byte_o); // R10
endmodule

bind lsu_agen lsu_agen_chk u_chk (.*);

// File: tb/lsu_agen_tb_top.sv
module lsu_agen_tb_top;
  typedef struct packed {
    logic [1:0]  mode;
    logic        sub;
    logic        oreg;
    logic        st;
    logic        byt;
    logic [31:0] base;
    logic [11:0] imm;
    logic [31:0] roff;
    logic [31:0] addr;
    logic        wben;
    logic [31:0] wbv;
  } vec_t;

  localparam int NV = 12;
  // R4 R5 R6 R7 R8 R9 R11 R12 cases
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 12'h004, 32'h0, 32'h0000_1004, 1'b0, 32'h0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2000, 12'h004, 32'h0, 32'h0000_1FFC, 1'b0, 32'h0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_3000, 12'h001, 32'h0, 32'h0000_2FFF, 1'b1, 32'h0000_2FFF},
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_5000, 12'h008, 32'h0, 32'h0000_5000, 1'b1, 32'h0000_5008},
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0700, 12'h000, 32'h40, 32'h0000_06C0, 1'b0, 32'h0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0100, 12'h000, 32'h23, 32'h0000_0123, 1'b1, 32'h0000_0123},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0010, 12'h000, 32'h20, 32'h0000_0010, 1'b1, 32'hFFFF_FFF0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE, 12'h005, 32'h0, 32'h0000_0003, 1'b0, 32'h0},
    '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0040, 12'h010, 32'h0, 32'h0000_0050, 1'b0, 32'h0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0123, 12'h000, 32'h55, 32'h0000_0123, 1'b0, 32'h0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 12'hFFF, 32'h0, 32'h0000_0FFF, 1'b0, 32'h0},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 12'h007, 32'h100, 32'h0000_0100, 1'b0, 32'h0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [11:0] imm_i = '0;
  logic [31:0] roff_i = '0;
  logic        off_reg_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        store_i = 1'b0;
  logic        byte_i = 1'b0;
  logic [31:0] addr_o, wb_val_o;
  logic        rd_o, wr_o, byte_o, word_o, wb_en_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  lsu_agen dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic quiet_chk(input string req);
    chk(req, {29'd0, rd_o, wr_o, wb_en_o}, 32'd0);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1 in reset", {27'd0, rd_o, wr_o, wb_en_o, byte_o, word_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {27'd0, rd_o, wr_o, wb_en_o, byte_o, word_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      valid_i   = 1'b1;
      mode_i    = VECS[i].mode;
      sub_i     = VECS[i].sub;
      off_reg_i = VECS[i].oreg;
      store_i   = VECS[i].st;
      byte_i    = VECS[i].byt;
      base_i    = VECS[i].base;
      imm_i     = VECS[i].imm;
      roff_i    = VECS[i].roff;
      @(negedge clk_i);
      valid_i = 1'b0;
      chk("R4/R5/R6/R7/R8/R9 addr", addr_o, VECS[i].addr);
      chk("R5/R6/R11 wb_en", {31'd0, wb_en_o}, {31'd0, VECS[i].wben});
      if (VECS[i].wben) chk("R5/R6 wb_val", wb_val_o, VECS[i].wbv);
      chk("R3 dir", {30'd0, rd_o, wr_o}, {30'd0, ~VECS[i].st, VECS[i].st});
      chk("R10 size", {30'd0, byte_o, word_o}, {30'd0, VECS[i].byt, ~VECS[i].byt});
      @(negedge clk_i);
      quiet_chk("R2 pulse ends");
    end

    // R2: back-to-back requests each last one cycle and update in turn
    valid_i = 1'b1; mode_i = 2'd1; sub_i = 1'b0; off_reg_i = 1'b0;
    store_i = 1'b0; byte_i = 1'b0; base_i = 32'h8000_0000; imm_i = 12'h010;
    @(negedge clk_i);
    chk("R2 first of pair", addr_o, 32'h8000_0010);
    mode_i = 2'd2; store_i = 1'b1; base_i = 32'h0000_0003; imm_i = 12'h001;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R2 second of pair addr", addr_o, 32'h0000_0003);
    chk("R10 low bits kept", {30'd0, addr_o[1:0]}, 32'd3);
    chk("R6 second of pair wb", wb_val_o, 32'h0000_0004);
    chk("R3 second of pair wr", {30'd0, rd_o, wr_o}, 32'd1);
    @(negedge clk_i);
    quiet_chk("R2 idle after pair");

    // R1: reset mid-stream clears strobes
    valid_i = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", {27'd0, rd_o, wr_o, wb_en_o, byte_o, word_o}, 32'd0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule